// File: doc/BRIEF.md
# Ring-Counter Microcode Sequencer

This block is the control unit of a small bus-organized accumulator machine. A one-hot ring of six timing states advances once per clock. The first three states are a fixed fetch. The last three carry out the instruction whose 4-bit opcode the instruction register presents. In every state the block produces a 12-bit control word. It also brings each bit of that word out as a separate strobe to the datapath, which the block does not contain.

Some bits of the control word are active high and others are active low. The bit position of each strobe is fixed, because the datapath decodes the word by position. A halt opcode stops the ring and raises a sticky halt flag. A synchronous clear restarts the sequence from the first state.

Top module: `ring_sequencer`

## Requirements
- R1: While `clr` is high, `ctrl_word` is 0x3E3. After a clock edge with `clr` high, `tstate` is 6'b000001 and `halted` is 0. This holds whatever state the sequencer was in before the clear.
- R2: `tstate` is always one-hot. When the sequencer is neither cleared nor halted, each clock edge moves the hot bit one place up: 000001, 000010, 000100, 001000, 010000, 100000, then back to 000001.
- R3: The fetch words do not depend on `opcode`. They are 0x5E3 in state 000001, 0xBE3 in state 000010 and 0x263 in state 000100.
- R4: For opcode 4'b0000 (load), the words in states 001000, 010000 and 100000 are 0x1A3, 0x2C3 and 0x3E3.
- R5: For opcode 4'b0001 (add), the execute words are 0x1A3, 0x2E1 and 0x3C7.
- R6: For opcode 4'b0010 (subtract), the execute words are 0x1A3, 0x2E1 and 0x3CF.
- R7: For opcode 4'b1110 (output), the execute words are 0x3F2, 0x3E3 and 0x3E3.
- R8: Opcode 4'b1111 (halt) seen in state 001000 gives the word 0x3E3 in that cycle. From the next edge on, `halted` is 1 and `tstate` stays at 001000 whatever `opcode` does, and `ctrl_word` stays 0x3E3 until a clear.
- R9: Any other opcode gives the idle word 0x3E3 in all three execute states, and the ring keeps running.
- R10: The strobes follow the bits of `ctrl_word` from bit 11 down to bit 0 in this order: `pc_inc`, `pc_drive`, `mar_load_n`, `ram_drive_n`, `ir_load_n`, `ir_drive_n`, `acc_load_n`, `acc_drive`, `sub_sel`, `sum_drive`, `b_load_n`, `out_load_n`. Names ending in `_n` are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear, active high |
| opcode | input | 4 | Upper nibble of the instruction register |
| tstate | output | 6 | One-hot timing state |
| ctrl_word | output | 12 | Full control word |
| pc_inc | output | 1 | Program counter count enable |
| pc_drive | output | 1 | Program counter onto bus |
| mar_load_n | output | 1 | Address register load, active low |
| ram_drive_n | output | 1 | Memory onto bus, active low |
| ir_load_n | output | 1 | Instruction register load, active low |
| ir_drive_n | output | 1 | Instruction operand onto bus, active low |
| acc_load_n | output | 1 | Accumulator load, active low |
| acc_drive | output | 1 | Accumulator onto bus |
| sub_sel | output | 1 | Subtract instead of add |
| sum_drive | output | 1 | Adder result onto bus |
| b_load_n | output | 1 | B register load, active low |
| out_load_n | output | 1 | Output register load, active low |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench builds the sequencer with its default opcode parameters, which are the five encodings listed above. With those values every row of the fetch and execute tables can be checked against a fixed expectation. The undefined opcodes 0x5 and 0x7 show the fall-through to the idle word. A clear issued in the middle of a fetch and a clear issued while halted test recovery from both kinds of frozen or partial state. Changing the opcode during fetch and during the halt shows that `opcode` has no effect in those states.

// File: rtl/ring_sequencer.sv
module ring_sequencer #(
  parameter logic [3:0] OP_LDA = 4'h0,
  parameter logic [3:0] OP_ADD = 4'h1,
  parameter logic [3:0] OP_SUB = 4'h2,
  parameter logic [3:0] OP_OUT = 4'hE,
  parameter logic [3:0] OP_HLT = 4'hF
) (
  input  logic        clk,
  input  logic        clr,
  input  logic [3:0]  opcode,
  output logic [5:0]  tstate,
  output logic [11:0] ctrl_word,
  output logic        pc_inc,
  output logic        pc_drive,
  output logic        mar_load_n,
  output logic        ram_drive_n,
  output logic        ir_load_n,
  output logic        ir_drive_n,
  output logic        acc_load_n,
  output logic        acc_drive,
  output logic        sub_sel,
  output logic        sum_drive,
  output logic        b_load_n,
  output logic        out_load_n,
  output logic        halted
);
  localparam logic [11:0] W_IDLE  = 12'h3E3;
  localparam logic [11:0] W_ADDR  = 12'h5E3;
  localparam logic [11:0] W_INCR  = 12'hBE3;
  localparam logic [11:0] W_MEM   = 12'h263;
  localparam logic [11:0] W_OPND  = 12'h1A3;
  localparam logic [11:0] W_RDA   = 12'h2C3;
  localparam logic [11:0] W_RDB   = 12'h2E1;
  localparam logic [11:0] W_SUM   = 12'h3C7;
  localparam logic [11:0] W_DIFF  = 12'h3CF;
  localparam logic [11:0] W_EMIT  = 12'h3F2;

  logic [5:0]  ring;
  logic        halt_q;
  logic        halt_now;
  logic [11:0] exec_w;
  logic [11:0] word;

  assign halt_now = ring[3] && (opcode == OP_HLT) && !halt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      ring   <= 6'b000001;
      halt_q <= 1'b0;
    end else if (halt_q || halt_now) begin
      halt_q <= 1'b1;
    end else begin
      ring <= {ring[4:0], ring[5]};
    end
  end

  always_comb begin
    exec_w = W_IDLE;
    unique case (1'b1)
      ring[3]: begin
        if (opcode == OP_LDA || opcode == OP_ADD || opcode == OP_SUB) exec_w = W_OPND;
        else if (opcode == OP_OUT) exec_w = W_EMIT;
      end
      ring[4]: begin
        if (opcode == OP_LDA) exec_w = W_RDA;
        else if (opcode == OP_ADD || opcode == OP_SUB) exec_w = W_RDB;
      end
      ring[5]: begin
        if (opcode == OP_ADD) exec_w = W_SUM;
        else if (opcode == OP_SUB) exec_w = W_DIFF;
      end
      default: exec_w = W_IDLE;
    endcase
  end

  always_comb begin
    word = W_IDLE;
    if (!clr && !halt_q) begin
      if (ring[0])      word = W_ADDR;
      else if (ring[1]) word = W_INCR;
      else if (ring[2]) word = W_MEM;
      else              word = exec_w;
    end
  end

  assign tstate    = ring;
  assign halted    = halt_q;
  assign ctrl_word = word;
  assign {pc_inc, pc_drive, mar_load_n, ram_drive_n, ir_load_n, ir_drive_n,
          acc_load_n, acc_drive, sub_sel, sum_drive, b_load_n, out_load_n} = word;
endmodule

module ring_sequencer_chk (
  input logic        clk,
  input logic        clr,
  input logic [3:0]  opcode,
  input logic [5:0]  tstate,
  input logic [11:0] ctrl_word,
  input logic        halted
);
  assert_clear_idle_R1: assert property (@(posedge clk)
    clr |-> ctrl_word == 12'h3E3);
  assert_clear_to_first_R1: assert property (@(posedge clk)
    clr |=> (tstate == 6'b000001) && !halted);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (clr)
    $onehot(tstate));
  assert_rotate_R2: assert property (@(posedge clk) disable iff (clr)
    (!halted && !(tstate[3] && opcode == 4'hF)) |=>
      tstate == {$past(tstate[4:0]), $past(tstate[5])});
  assert_fetch_addr_R3: assert property (@(posedge clk) disable iff (clr)
    (tstate[0] && !halted) |-> ctrl_word == 12'h5E3);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (clr)
    halted |=> halted && $stable(tstate));
  assert_halt_idle_R8: assert property (@(posedge clk) disable iff (clr)
    halted |-> ctrl_word == 12'h3E3);
endmodule

bind ring_sequencer ring_sequencer_chk u_chk (
  .clk(clk), .clr(clr), .opcode(opcode), .tstate(tstate),
  .ctrl_word(ctrl_word), .halted(halted)
);

// File: tb/ring_sequencer_test.sv
module ring_sequencer_test;
  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [3:0]  opcode = 4'h0;
  logic [5:0]  tstate;
  logic [11:0] ctrl_word;
  logic        pc_inc, pc_drive, mar_load_n, ram_drive_n, ir_load_n, ir_drive_n;
  logic        acc_load_n, acc_drive, sub_sel, sum_drive, b_load_n, out_load_n;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [5:0]  t;
    logic [11:0] w;
    logic        h;
    string       req;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  ring_sequencer uut (
    .clk(clk), .clr(clr), .opcode(opcode), .tstate(tstate), .ctrl_word(ctrl_word),
    .pc_inc(pc_inc), .pc_drive(pc_drive), .mar_load_n(mar_load_n),
    .ram_drive_n(ram_drive_n), .ir_load_n(ir_load_n), .ir_drive_n(ir_drive_n),
    .acc_load_n(acc_load_n), .acc_drive(acc_drive), .sub_sel(sub_sel),
    .sum_drive(sum_drive), .b_load_n(b_load_n), .out_load_n(out_load_n),
    .halted(halted)
  );

  function automatic logic [11:0] exp_w(int k, logic [3:0] op);
    case (k)
      0: return 12'h5E3;
      1: return 12'hBE3;
      2: return 12'h263;
      3: return (op == 4'h0 || op == 4'h1 || op == 4'h2) ? 12'h1A3 :
                (op == 4'hE) ? 12'h3F2 : 12'h3E3;
      4: return (op == 4'h0) ? 12'h2C3 :
                (op == 4'h1 || op == 4'h2) ? 12'h2E1 : 12'h3E3;
      default: return (op == 4'h1) ? 12'h3C7 : (op == 4'h2) ? 12'h3CF : 12'h3E3;
    endcase
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op)
      4'h0: return "R4";
      4'h1: return "R5";
      4'h2: return "R6";
      4'hE: return "R7";
      4'hF: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(input logic c, input logic [3:0] op, input logic [5:0] t,
                      input logic [11:0] w, input logic h, input string req);
    @(negedge clk);
    clr = c;
    opcode = op;
    q.push_back('{t: t, w: w, h: h, req: req});
  endtask

  task automatic instr(input logic [3:0] op, input logic [3:0] fop);
    for (int k = 0; k < 6; k++)
      step(1'b0, (k < 3) ? fop : op, 6'b000001 << k, exp_w(k, op), 1'b0,
           (k < 3) ? "R3" : tag(op));
  endtask

  always @(negedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      logic [11:0] strobes;
      it = q.pop_front();
      strobes = {pc_inc, pc_drive, mar_load_n, ram_drive_n, ir_load_n, ir_drive_n,
                 acc_load_n, acc_drive, sub_sel, sum_drive, b_load_n, out_load_n};
      checks++;
      if (tstate !== it.t || ctrl_word !== it.w || halted !== it.h) begin
        fails++;
        $display("FAIL %s: t=%b w=%h h=%b expected t=%b w=%h h=%b",
                 it.req, tstate, ctrl_word, halted, it.t, it.w, it.h);
      end
      checks++;
      if (strobes !== it.w) begin
        fails++;
        $display("FAIL R10: strobes=%h expected %h", strobes, it.w);
      end
    end
  end

  initial begin
    step(1'b1, 4'h0, 6'b000001, 12'h3E3, 1'b0, "R1");
    instr(4'h0, 4'h3);
    instr(4'h1, 4'hF);
    instr(4'h2, 4'hE);
    instr(4'hE, 4'h1);
    instr(4'h5, 4'h0);
    instr(4'h7, 4'h2);
    // R1: clear in the middle of a fetch
    step(1'b0, 4'h1, 6'b000001, 12'h5E3, 1'b0, "R3");
    step(1'b0, 4'h1, 6'b000010, 12'hBE3, 1'b0, "R3");
    step(1'b1, 4'h1, 6'b000100, 12'h3E3, 1'b0, "R1");
    instr(4'h2, 4'h2);
    // R8: halt, then opcode changes have no effect
    for (int k = 0; k < 3; k++)
      step(1'b0, 4'hF, 6'b000001 << k, exp_w(k, 4'hF), 1'b0, "R3");
    step(1'b0, 4'hF, 6'b001000, 12'h3E3, 1'b0, "R8");
    step(1'b0, 4'h0, 6'b001000, 12'h3E3, 1'b1, "R8");
    step(1'b0, 4'h1, 6'b001000, 12'h3E3, 1'b1, "R8");
    step(1'b0, 4'hE, 6'b001000, 12'h3E3, 1'b1, "R8");
    step(1'b0, 4'h2, 6'b001000, 12'h3E3, 1'b1, "R8");
    step(1'b1, 4'h0, 6'b001000, 12'h3E3, 1'b1, "R1");
    instr(4'h1, 4'h0);
    instr(4'h0, 4'h0);
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule